// File: doc/BRIEF.md
# Cyclic-Shift Multicode Spread-Spectrum Chip Generator

This block turns one symbol's worth of QPSK data for many parallel code channels into a stream of summed chips. All channels share one maximal-length binary sequence. Channel k uses that sequence advanced cyclically by k times a shift step. Channel 0 carries a fixed pilot symbol and every other active channel carries one 2-bit QPSK symbol. For each chip, the block adds the products of channel symbol and code chip over all active channels, separately on the I and Q rails. Each symbol is preceded by a cyclic prefix of guard chips, so that multipath delay spread up to the guard length does not leak into the next symbol.

Two inputs set the configuration. The first selects the sequence length: 31 chips from a 5-stage register or 63 chips from a 6-stage register. The second selects the shift step: either the guard length, which gives a few widely spaced codes, or one chip, which gives the densest code set. A symbol word is taken with a valid/ready handshake. Output chips come one per clock while `chip_valid` is high, and `chip_first` marks the first chip of each symbol.

The controller is a three-state machine:
- IDLE waits for a symbol, with ready high.
- GUARD emits the prefix chips.
- BODY emits the full sequence.

Its transitions are:
- IDLE→GUARD when a symbol is accepted.
- GUARD→BODY after the last prefix chip.
- BODY→GUARD when a new symbol is accepted on the last body chip.
- BODY→IDLE when the last body chip passes with no symbol offered.

Top module: `dsss_multicode_spreader`

## Requirements
- R1: After reset, `chip_valid` is 0 and `sym_ready` is 1.
- R2: A symbol is sent as G+L consecutive chips with `chip_valid` high throughout, and `chip_first` is high on the first of them only. For `cfg_long`=0, G=5 and L=31 (36 chips). For `cfg_long`=1, G=9 and L=63 (72 chips).
- R3: The base sequence bit s[n] is 1 for n < m. For n ≥ m it is s[n-m] XOR s[n-m+t], where (m,t) = (5,2) for `cfg_long`=0 (x^5+x^2+1) and (6,1) for `cfg_long`=1 (x^6+x+1). Chip bit 0 means +1 and chip bit 1 means −1.
- R4: The chip of code k at sequence position n is s[(n + k·S) mod L]. S = G when `cfg_dense`=0 and S = 1 when `cfg_dense`=1.
- R5: The number of active codes is N = floor(L/S): 6, 7, 31 or 63. Code 0 is the pilot and carries +1 on I and on Q.
- R6: Data channel k (1 ≤ k < N) takes its I bit from `sym_bits[2k-2]` and its Q bit from `sym_bits[2k-1]`. Bit 0 maps to +1 and bit 1 maps to −1. Each chip output is the sum over active codes of symbol times code chip.
- R7: Chip j of a symbol (0 ≤ j < G+L) uses sequence position (j + L − G) mod L. So the G prefix chips repeat the last G body chips.
- R8: A symbol is accepted on a clock edge where `sym_valid` and `sym_ready` are both 1, and its first chip appears in the following cycle. `sym_ready` is 1 in IDLE and on the last body chip, and 0 otherwise.
- R9: A symbol accepted on the last body chip follows the current one with no idle cycle.
- R10: Configuration and data are captured at acceptance. Changes to `cfg_long`, `cfg_dense` or `sym_bits` during a symbol have no effect on it.
- R11: `sym_bits` above bit 2(N−1)−1 have no effect on the output.
- R12: `chip_i` and `chip_q` are two's complement of width SUM_W (8) and stay within ±N, so they never overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_long | input | 1 | 0: 31-chip sequence with 5 guard chips; 1: 63-chip sequence with 9 guard chips |
| cfg_dense | input | 1 | 0: shift step equals guard length; 1: shift step of one chip |
| sym_valid | input | 1 | A symbol word is offered |
| sym_ready | output | 1 | The block can take a symbol this cycle |
| sym_bits | input | 124 | QPSK bits for data channels 1..62, two per channel |
| chip_valid | output | 1 | `chip_i`/`chip_q` carry a chip |
| chip_first | output | 1 | First chip of a symbol |
| chip_i | output | 8 | Signed I chip sum |
| chip_q | output | 8 | Signed Q chip sum |

## Verification
A wrong sequence register or rotation state shows up as a wrong chip sum in the very next output cycle. A wrong sequence or rotation in a single code flips that code's contribution by ±2 on some chips of the symbol. A wrong prefix offset corrupts the first G chips of every symbol. A controller that miscounts its phases changes where `chip_first` falls or where `sym_ready` rises, and this is visible within one symbol of 36 or 72 chips. The bench sweeps all four configurations with structured and pseudo-random data. It compares every chip against sums computed from the requirements, and it changes the inputs during a symbol to show that captured state is held.

// File: rtl/dsss_pkg.sv
package dsss_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GUARD = 2'd1,
        ST_BODY  = 2'd2
    } chip_state_e;

endpackage

// File: rtl/dsss_chip_ctrl.sv
module dsss_chip_ctrl
    import dsss_pkg::*;
#(
    parameter int SHORT_LEN   = 31,
    parameter int LONG_LEN    = 63,
    parameter int SHORT_GUARD = 5,
    parameter int LONG_GUARD  = 9,
    parameter int CNT_W       = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sym_valid,
    input  logic mode_long,
    output logic sym_ready,
    output logic accept,
    output logic advance,
    output logic chip_valid,
    output logic chip_first
);

    chip_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] seq_last, guard_last;
    logic body_last;

    assign seq_last   = mode_long ? CNT_W'(LONG_LEN - 1)   : CNT_W'(SHORT_LEN - 1);
    assign guard_last = mode_long ? CNT_W'(LONG_GUARD - 1) : CNT_W'(SHORT_GUARD - 1);
    assign body_last  = (state_q == ST_BODY) && (cnt_q == seq_last);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_GUARD;
                    cnt_d   = '0;
                end
            end
            ST_GUARD: begin
                if (cnt_q == guard_last) begin
                    state_d = ST_BODY;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_BODY: begin
                if (body_last) begin
                    state_d = accept ? ST_GUARD : ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        sym_ready  = 1'b0;
        chip_valid = 1'b0;
        chip_first = 1'b0;
        unique case (state_q)
            ST_IDLE:  sym_ready = 1'b1;
            ST_GUARD: begin
                chip_valid = 1'b1;
                chip_first = (cnt_q == '0);
            end
            ST_BODY: begin
                chip_valid = 1'b1;
                sym_ready  = body_last;
            end
            default: ;
        endcase
        accept  = sym_valid && sym_ready;
        advance = chip_valid;
    end

    p_first_follows_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_ready) |=> chip_first);

    p_no_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_valid && !sym_ready) |=> chip_valid);

    p_ready_low_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chip_first |-> !sym_ready);

endmodule

// File: rtl/dsss_code_window.sv
module dsss_code_window #(
    parameter int SHORT_STAGES = 5,
    parameter int SHORT_TAP    = 2,
    parameter int SHORT_GUARD  = 5,
    parameter int LONG_STAGES  = 6,
    parameter int LONG_TAP     = 1,
    parameter int LONG_GUARD   = 9,
    parameter int SHORT_LEN    = (1 << SHORT_STAGES) - 1,
    parameter int LONG_LEN     = (1 << LONG_STAGES) - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                load_long,
    input  logic                advance,
    input  logic                mode_long,
    output logic [LONG_LEN-1:0] win
);

    // maximal-length sequence, bit n of the result is sequence chip n
    function automatic logic [LONG_LEN-1:0] gen_seq(input int stages, input int tap, input int len);
        logic [LONG_LEN-1:0] s;
        s = '0;
        for (int n = 0; n < len; n++) begin
            if (n < stages) s[n] = 1'b1;
            else            s[n] = s[n-stages] ^ s[n-stages+tap];
        end
        return s;
    endfunction

    // window bit j holds sequence chip (off + j) mod len
    function automatic logic [LONG_LEN-1:0] rot_seq(input logic [LONG_LEN-1:0] s, input int len, input int off);
        logic [LONG_LEN-1:0] r;
        r = '0;
        for (int j = 0; j < len; j++) r[j] = s[(off + j) % len];
        return r;
    endfunction

    localparam logic [LONG_LEN-1:0] SHORT_SEQ  = gen_seq(SHORT_STAGES, SHORT_TAP, SHORT_LEN);
    localparam logic [LONG_LEN-1:0] LONG_SEQ   = gen_seq(LONG_STAGES, LONG_TAP, LONG_LEN);
    localparam logic [LONG_LEN-1:0] SHORT_INIT = rot_seq(SHORT_SEQ, SHORT_LEN, SHORT_LEN - SHORT_GUARD);
    localparam logic [LONG_LEN-1:0] LONG_INIT  = rot_seq(LONG_SEQ, LONG_LEN, LONG_LEN - LONG_GUARD);
    localparam int SHORT_ONES = 1 << (SHORT_STAGES - 1);
    localparam int LONG_ONES  = 1 << (LONG_STAGES - 1);

    logic [LONG_LEN-1:0] win_rot;

    always_comb begin
        win_rot = win;
        if (mode_long) begin
            win_rot = {win[0], win[LONG_LEN-1:1]};
        end else begin
            win_rot[SHORT_LEN-1:0] = {win[0], win[SHORT_LEN-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win <= '0;
        end else if (load) begin
            win <= load_long ? LONG_INIT : SHORT_INIT;
        end else if (advance) begin
            win <= win_rot;
        end
    end

    p_load_weight_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ($countones(win) == ($past(load_long) ? LONG_ONES : SHORT_ONES)));

    p_rotate_weight_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> ($countones(win) == $past($countones(win))));

endmodule

// File: rtl/dsss_chip_combiner.sv
module dsss_chip_combiner #(
    parameter int SHORT_LEN   = 31,
    parameter int LONG_LEN    = 63,
    parameter int SHORT_GUARD = 5,
    parameter int LONG_GUARD  = 9,
    parameter int SUM_W       = 8,
    parameter int DATA_W      = 2 * (LONG_LEN - 1)
) (
    input  logic [LONG_LEN-1:0]     win,
    input  logic [DATA_W-1:0]       data,
    input  logic                    mode_long,
    input  logic                    dense,
    output logic signed [SUM_W-1:0] sum_i,
    output logic signed [SUM_W-1:0] sum_q,
    output logic [7:0]              code_cnt
);

    localparam int SS_N = SHORT_LEN / SHORT_GUARD;
    localparam int LS_N = LONG_LEN / LONG_GUARD;

    logic [LONG_LEN-1:0] neg_i, neg_q;

    always_comb begin
        unique case ({mode_long, dense})
            2'b00:   code_cnt = 8'(SS_N);
            2'b10:   code_cnt = 8'(LS_N);
            2'b01:   code_cnt = 8'(SHORT_LEN);
            default: code_cnt = 8'(LONG_LEN);
        endcase
    end

    for (genvar k = 0; k < LONG_LEN; k++) begin : g_code
        localparam int IDX_SS = (k < SS_N) ? k * SHORT_GUARD : 0;
        localparam int IDX_LS = (k < LS_N) ? k * LONG_GUARD : 0;
        localparam int IDX_SD = (k < SHORT_LEN) ? k : 0;
        localparam logic ACT_SS = (k < SS_N);
        localparam logic ACT_LS = (k < LS_N);
        localparam logic ACT_SD = (k < SHORT_LEN);
        logic chip_b, act, di, dq;

        always_comb begin
            unique case ({mode_long, dense})
                2'b00: begin chip_b = win[IDX_SS]; act = ACT_SS; end
                2'b10: begin chip_b = win[IDX_LS]; act = ACT_LS; end
                2'b01: begin chip_b = win[IDX_SD]; act = ACT_SD; end
                default: begin chip_b = win[k]; act = 1'b1; end
            endcase
        end

        if (k == 0) begin : g_pilot
            assign di = 1'b0;
            assign dq = 1'b0;
        end else begin : g_data
            assign di = data[2*k-2];
            assign dq = data[2*k-1];
        end

        assign neg_i[k] = act & (di ^ chip_b);
        assign neg_q[k] = act & (dq ^ chip_b);
    end

    always_comb begin
        sum_i = SUM_W'(int'(code_cnt) - 2 * int'($countones(neg_i)));
        sum_q = SUM_W'(int'(code_cnt) - 2 * int'($countones(neg_q)));
    end

endmodule

// File: rtl/dsss_multicode_spreader.sv
module dsss_multicode_spreader #(
    parameter int SHORT_STAGES = 5,
    parameter int SHORT_TAP    = 2,
    parameter int SHORT_GUARD  = 5,
    parameter int LONG_STAGES  = 6,
    parameter int LONG_TAP     = 1,
    parameter int LONG_GUARD   = 9,
    parameter int SUM_W        = 8,
    parameter int SHORT_LEN    = (1 << SHORT_STAGES) - 1,
    parameter int LONG_LEN     = (1 << LONG_STAGES) - 1,
    parameter int DATA_W       = 2 * (LONG_LEN - 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_long,
    input  logic                    cfg_dense,
    input  logic                    sym_valid,
    output logic                    sym_ready,
    input  logic [DATA_W-1:0]       sym_bits,
    output logic                    chip_valid,
    output logic                    chip_first,
    output logic signed [SUM_W-1:0] chip_i,
    output logic signed [SUM_W-1:0] chip_q
);

    localparam int CNT_W = $clog2(LONG_LEN + LONG_GUARD);

    logic                accept, advance;
    logic                long_q, dense_q;
    logic [DATA_W-1:0]   data_q;
    logic [LONG_LEN-1:0] win;
    logic [7:0]          code_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            long_q  <= 1'b0;
            dense_q <= 1'b0;
            data_q  <= '0;
        end else if (accept) begin
            long_q  <= cfg_long;
            dense_q <= cfg_dense;
            data_q  <= sym_bits;
        end
    end

    dsss_chip_ctrl #(
        .SHORT_LEN  (SHORT_LEN),
        .LONG_LEN   (LONG_LEN),
        .SHORT_GUARD(SHORT_GUARD),
        .LONG_GUARD (LONG_GUARD),
        .CNT_W      (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .mode_long (long_q),
        .sym_ready (sym_ready),
        .accept    (accept),
        .advance   (advance),
        .chip_valid(chip_valid),
        .chip_first(chip_first)
    );

    dsss_code_window #(
        .SHORT_STAGES(SHORT_STAGES),
        .SHORT_TAP   (SHORT_TAP),
        .SHORT_GUARD (SHORT_GUARD),
        .LONG_STAGES (LONG_STAGES),
        .LONG_TAP    (LONG_TAP),
        .LONG_GUARD  (LONG_GUARD),
        .SHORT_LEN   (SHORT_LEN),
        .LONG_LEN    (LONG_LEN)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_long(cfg_long),
        .advance  (advance),
        .mode_long(long_q),
        .win      (win)
    );

    dsss_chip_combiner #(
        .SHORT_LEN  (SHORT_LEN),
        .LONG_LEN   (LONG_LEN),
        .SHORT_GUARD(SHORT_GUARD),
        .LONG_GUARD (LONG_GUARD),
        .SUM_W      (SUM_W),
        .DATA_W     (DATA_W)
    ) u_comb (
        .win      (win),
        .data     (data_q),
        .mode_long(long_q),
        .dense    (dense_q),
        .sum_i    (chip_i),
        .sum_q    (chip_q),
        .code_cnt (code_cnt)
    );

    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        chip_valid |-> ((int'(chip_i) <= int'(code_cnt)) && (int'(chip_i) >= -int'(code_cnt))
                     && (int'(chip_q) <= int'(code_cnt)) && (int'(chip_q) >= -int'(code_cnt))));

    p_config_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_valid && !sym_ready) |=> $stable(long_q) && $stable(dense_q));

endmodule

// File: tb/tb_dsss_multicode_spreader.sv
module tb_dsss_multicode_spreader;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_long = 1'b0;
    logic         cfg_dense = 1'b0;
    logic         sym_valid = 1'b0;
    logic         sym_ready;
    logic [123:0] sym_bits = '0;
    logic         chip_valid, chip_first;
    logic signed [7:0] chip_i, chip_q;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    bit base_s [63];
    bit base_l [63];

    logic [123:0] b_dat [4];
    bit           b_lng [4];
    bit           b_dns [4];
    int unsigned  seed = 32'h1234_5678;

    always #10 clk = ~clk;

    dsss_multicode_spreader dut (
        .clk(clk), .rst_n(rst_n), .cfg_long(cfg_long), .cfg_dense(cfg_dense),
        .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_bits(sym_bits),
        .chip_valid(chip_valid), .chip_first(chip_first), .chip_i(chip_i), .chip_q(chip_q)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 60000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 60000);
            summary();
            $finish;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // sequence per R3: s[n] = 1 for n < m, else s[n-m] ^ s[n-m+t]
    task automatic build_base();
        for (int n = 0; n < 31; n++) base_s[n] = (n < 5) ? 1'b1 : (base_s[n-5] ^ base_s[n-3]);
        for (int n = 0; n < 63; n++) base_l[n] = (n < 6) ? 1'b1 : (base_l[n-6] ^ base_l[n-5]);
    endtask

    function automatic int exp_sum(logic [123:0] d, bit lng, bit dns, int p, bit qsel);
        int len, g, s, ncodes, n, sum;
        bit c, a;
        len = lng ? 63 : 31;
        g = lng ? 9 : 5;
        s = dns ? 1 : g;
        ncodes = len / s;
        n = (p + len - g) % len;
        sum = 0;
        for (int k = 0; k < ncodes; k++) begin
            c = lng ? base_l[(n + k * s) % len] : base_s[(n + k * s) % len];
            a = (k == 0) ? 1'b0 : d[2 * k - 2 + qsel];
            sum += (a ^ c) ? -1 : 1;
        end
        return sum;
    endfunction

    function automatic logic [123:0] rnd_word();
        logic [123:0] w;
        for (int i = 0; i < 4; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            w[i*31 +: 31] = seed[31:1];
        end
        return w;
    endfunction

    task automatic drive(int idx);
        sym_valid = 1'b1;
        cfg_long  = b_lng[idx];
        cfg_dense = b_dns[idx];
        sym_bits  = b_dat[idx];
    endtask

    task automatic run_burst(int nsym, string tag);
        @(negedge clk);
        chk("R8", "ready in idle", int'(sym_ready), 1);
        drive(0);
        for (int s = 0; s < nsym; s++) begin
            int len, g, tot;
            len = b_lng[s] ? 63 : 31;
            g = b_lng[s] ? 9 : 5;
            tot = len + g;
            for (int p = 0; p < tot; p++) begin
                @(negedge clk);
                chk("R2", "chip_valid", int'(chip_valid), 1);
                chk("R2", "chip_first", int'(chip_first), (p == 0) ? 1 : 0);
                chk((p < g) ? "R7" : tag, "chip_i", int'(chip_i), exp_sum(b_dat[s], b_lng[s], b_dns[s], p, 1'b0));
                chk((p < g) ? "R7" : tag, "chip_q", int'(chip_q), exp_sum(b_dat[s], b_lng[s], b_dns[s], p, 1'b1));
                if (p == 0) begin
                    // R10: disturb inputs while the symbol is in flight
                    sym_valid = 1'b0;
                    cfg_long  = ~b_lng[s];
                    cfg_dense = ~b_dns[s];
                    sym_bits  = ~b_dat[s];
                end
                if (p == 1) chk("R8", "ready mid symbol", int'(sym_ready), 0);
                if (p == tot - 1) begin
                    chk("R8", "ready on last chip", int'(sym_ready), 1);
                    if (s < nsym - 1) drive(s + 1);
                end
            end
        end
        @(negedge clk);
        chk("R8", "idle after burst", int'(chip_valid), 0);
        chk("R1", "ready after burst", int'(sym_ready), 1);
    endtask

    initial begin
        build_base();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "chip_valid in reset", int'(chip_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "chip_valid after reset", int'(chip_valid), 0);
        chk("R1", "ready after reset", int'(sym_ready), 1);
        repeat (3) @(negedge clk);
        chk("R8", "no chips without request", int'(chip_valid), 0);

        // R3 R4 R5: all-zero data, short sparse
        b_dat[0] = '0; b_lng[0] = 0; b_dns[0] = 0;
        run_burst(1, "R4");
        // R11: short sparse, active bits one, unused bits random
        b_dat[0] = rnd_word(); b_dat[0][9:0] = '1; b_lng[0] = 0; b_dns[0] = 0;
        run_burst(1, "R11");
        // R5 R6: long sparse, alternating bits
        b_dat[0] = {31{4'b0101}}; b_lng[0] = 1; b_dns[0] = 0;
        run_burst(1, "R5");
        // R11: short dense, random including unused upper half
        b_dat[0] = rnd_word(); b_lng[0] = 0; b_dns[0] = 1;
        run_burst(1, "R11");
        // R3 R6: long dense, zeros then ones then random
        b_dat[0] = '0; b_lng[0] = 1; b_dns[0] = 1;
        run_burst(1, "R3");
        b_dat[0] = '1; b_lng[0] = 1; b_dns[0] = 1;
        run_burst(1, "R6");
        for (int r = 0; r < 6; r++) begin
            b_dat[0] = rnd_word(); b_lng[0] = r[0]; b_dns[0] = r[1];
            run_burst(1, "R6");
        end
        // R9 R10: back-to-back mixed configurations
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 4; i++) begin
                b_dat[i] = rnd_word();
                b_lng[i] = (i + r) % 2 == 1;
                b_dns[i] = (i / 2 + r) % 2 == 1;
            end
            run_burst(4, "R9");
        end
        for (int i = 0; i < 4; i++) begin
            b_dat[i] = (i % 2 == 1) ? '1 : '0;
            b_lng[i] = 1'b1;
            b_dns[i] = i[0];
        end
        run_burst(4, "R10");

        done = 1;
        summary();
        $finish;
    end

endmodule